// File: doc/BRIEF.md
# Interrupt Redirection Table Controller

This block routes sixteen interrupt pins into a single stream of interrupt messages. Each pin has its own redirection entry, split into a low and a high 32-bit word. The entry gives the vector, the delivery mode, the destination mode, the polarity, the trigger mode, a mask and a destination. Software does not see the table directly. It writes an index into a select register, and then a data window reads or writes the register at that index. The same path reaches the controller's identification register at index 0.

A pin that is not masked raises a request. An edge-triggered pin latches an active-going edge, where polarity decides which transition counts. A level-triggered pin requests while it is active and has not yet been serviced. A small scheduler serves these requests. Its state machine has two states. In SCAN it waits. The transition SCAN→HOLD ("capture") fires on the first cycle with any request: it picks the lowest-numbered requesting pin and latches that pin's payload. In HOLD it drives `msg_valid`. The transition HOLD→SCAN ("accept") fires when `msg_ready` is high. That acceptance consumes an edge request, or marks a level pin as in service until its end-of-interrupt arrives.

Top module: `irq_route_ctrl`

## Requirements
- R1: A `sel_we` pulse stores `sel_wdata` as the current index from the next cycle. `win_rdata` always shows the register at the current index. A `win_we` pulse writes `win_wdata` into that register, and the new value is visible on the following cycle.
- R2: Index 0 is the identification register. Its bits 27:24 hold a 4-bit ID that resets to 0 and is writable. All of its other bits read 0.
- R3: Pin p has its low word at index 0x10+2p and its high word at index 0x11+2p. Low-word fields are: vector in bits 7:0, delivery mode in bits 10:8, destination mode in bit 11, polarity in bit 13 (1 = active low), trigger in bit 15 (1 = level), mask in bit 16. The high word holds the destination in bits 27:24. Every other bit reads 0. A message carries the vector, delivery mode, destination mode, destination and pin number of its entry.
- R4: After reset every entry reads low word 0x00010000 (masked, vector 0) and high word 0, and no message is offered.
- R5: A pin whose mask bit is set produces no message. An edge that occurs while the pin is masked is discarded and is not delivered after unmasking.
- R6: An edge pin latches the transition of its input to its active level (input XOR polarity going from 0 to 1). Each such edge yields exactly one message, and the latched request survives until that message is accepted. An input that stays active produces no further message.
- R7: A level pin requests while its input is active. After its message is accepted it sends nothing more until `eoi_valid` is pulsed with `eoi_pin` equal to that pin. If the input is still active at that point, the message is sent again. If it is inactive, nothing is sent.
- R8: When several pins request in the same cycle, the lowest-numbered pin is offered first and the others follow one per accepted message.
- R9: Once `msg_valid` rises, it and all payload outputs hold unchanged until a cycle with `msg_ready` high. `msg_valid` is low in the cycle after that acceptance. A request seen in cycle n is offered from cycle n+1.
- R10: Reading any index other than 0 and 0x10..0x2F returns 0. Writing such an index changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_we | input | 1 | Write strobe for the select register |
| sel_wdata | input | 8 | Index to select |
| win_we | input | 1 | Write strobe for the data window |
| win_wdata | input | 32 | Data written through the window |
| win_rdata | output | 32 | Register at the selected index |
| pin_in | input | 16 | Interrupt input pins |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_pin | input | 4 | Pin the end-of-interrupt refers to |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message taken by the receiver |
| msg_pin | output | 4 | Source pin of the message |
| msg_vector | output | 8 | Vector of the message |
| msg_dlv | output | 3 | Delivery mode of the message |
| msg_dmode | output | 1 | Destination mode of the message |
| msg_dest | output | 4 | Destination of the message |

## Verification
The bench targets several corner cases, and each one exposes a specific fault.
- An edge raised while the pin is masked must stay lost after unmasking. A design that latches edges regardless of the mask would send a late, unwanted message.
- An edge pin held high must produce exactly one message, and a level pin must stay silent between acceptance and its end-of-interrupt. Getting the in-service or edge logic wrong shows up as repeated messages.
- Two pins raised together must leave in ascending order. An inverted priority encoder would send the higher pin first.
- An active-low pin must fire on its falling input, and a level pin must fire again after end-of-interrupt only if it is still active.

Junk written into undefined bits and unmapped indices must read back as zero, which catches decode aliasing. A behavioural model compared on every clock catches payload, handshake-hold or timing slips.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;

    localparam int VEC_W      = 8;
    localparam int DLV_W      = 3;
    localparam int DEST_W     = 4;
    localparam int WORD_W     = 32;

    // low-word field positions, decoded by software
    localparam int LO_VEC_LSB = 0;
    localparam int LO_DLV_LSB = 8;
    localparam int LO_DMODE   = 11;
    localparam int LO_POL     = 13;
    localparam int LO_TRIG    = 15;
    localparam int LO_MASK    = 16;
    // high word and ID register share this field position
    localparam int FLD_HI_LSB = 24;

    typedef struct packed {
        logic              mask;
        logic              trig;   // 1 = level
        logic              pol;    // 1 = active low
        logic              dmode;
        logic [DLV_W-1:0]  dlv;
        logic [VEC_W-1:0]  vec;
        logic [DEST_W-1:0] dest;
    } rte_t;

    typedef struct packed {
        logic [VEC_W-1:0]  vec;
        logic [DLV_W-1:0]  dlv;
        logic              dmode;
        logic [DEST_W-1:0] dest;
    } msg_pay_t;

    localparam rte_t RTE_RESET = '{mask: 1'b1, default: '0};

    typedef enum logic {
        ST_SCAN = 1'b0,
        ST_HOLD = 1'b1
    } sched_st_e;

endpackage

// File: rtl/irq_route_regs.sv
`timescale 1ns/1ps
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int IDX_W    = 8,
    parameter int BASE_IDX = 16,
    parameter int ID_W     = 4,
    parameter int ID_RESET = 0,
    localparam int PIN_W   = $clog2(NUM_PINS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sel_we,
    input  logic [IDX_W-1:0]          sel_wdata,
    input  logic                      win_we,
    input  logic [WORD_W-1:0]         win_wdata,
    output logic [WORD_W-1:0]         win_rdata,
    output rte_t [NUM_PINS-1:0]       tbl
);

    localparam logic [IDX_W-1:0] BASE_V = IDX_W'(BASE_IDX);
    localparam logic [IDX_W-1:0] LAST_V = IDX_W'(BASE_IDX + 2*NUM_PINS - 1);

    logic [IDX_W-1:0]      sel_q;
    logic [ID_W-1:0]       id_q;
    rte_t [NUM_PINS-1:0]   tbl_q;

    logic                  is_id;
    logic                  in_tbl;
    logic [IDX_W-1:0]      offs;
    logic [PIN_W-1:0]      pin_sel;
    logic                  is_hi;
    logic                  unused_wbits;

    assign unused_wbits = ^{win_wdata[31:28], win_wdata[23:17],
                            win_wdata[14], win_wdata[12]};

    assign is_id   = (sel_q == '0);
    assign in_tbl  = (sel_q >= BASE_V) && (sel_q <= LAST_V);
    assign offs    = sel_q - BASE_V;
    assign pin_sel = PIN_W'(offs >> 1);
    assign is_hi   = offs[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            id_q  <= ID_W'(ID_RESET);
        end else begin
            if (sel_we)
                sel_q <= sel_wdata;
            if (win_we && is_id)
                id_q <= win_wdata[FLD_HI_LSB +: ID_W];
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tbl_q[p] <= RTE_RESET;
            end else if (win_we && in_tbl && pin_sel == PIN_W'(p)) begin
                if (is_hi) begin
                    tbl_q[p].dest <= win_wdata[FLD_HI_LSB +: DEST_W];
                end else begin
                    tbl_q[p].vec   <= win_wdata[LO_VEC_LSB +: VEC_W];
                    tbl_q[p].dlv   <= win_wdata[LO_DLV_LSB +: DLV_W];
                    tbl_q[p].dmode <= win_wdata[LO_DMODE];
                    tbl_q[p].pol   <= win_wdata[LO_POL];
                    tbl_q[p].trig  <= win_wdata[LO_TRIG];
                    tbl_q[p].mask  <= win_wdata[LO_MASK];
                end
            end
        end
    end

    always_comb begin
        win_rdata = '0;
        if (is_id) begin
            win_rdata[FLD_HI_LSB +: ID_W] = id_q;
        end else if (in_tbl) begin
            if (is_hi) begin
                win_rdata[FLD_HI_LSB +: DEST_W] = tbl_q[pin_sel].dest;
            end else begin
                win_rdata[LO_VEC_LSB +: VEC_W] = tbl_q[pin_sel].vec;
                win_rdata[LO_DLV_LSB +: DLV_W] = tbl_q[pin_sel].dlv;
                win_rdata[LO_DMODE]            = tbl_q[pin_sel].dmode;
                win_rdata[LO_POL]              = tbl_q[pin_sel].pol;
                win_rdata[LO_TRIG]             = tbl_q[pin_sel].trig;
                win_rdata[LO_MASK]             = tbl_q[pin_sel].mask;
            end
        end
    end

    assign tbl = tbl_q;

    // R2: a window write at index 0 lands in the ID field
    p_id_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (win_we && is_id) |=> (id_q == $past(win_wdata[FLD_HI_LSB +: ID_W])));

    // R10: writes to unmapped indices leave every register alone
    p_unmapped_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (win_we && !is_id && !in_tbl) |=> ($stable(id_q) && $stable(tbl_q)));

endmodule

// File: rtl/irq_route_capture.sv
`timescale 1ns/1ps
module irq_route_capture #(
    parameter int NUM_PINS = 16,
    localparam int PIN_W   = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] mask_v,
    input  logic [NUM_PINS-1:0] trig_v,
    input  logic [NUM_PINS-1:0] pol_v,
    input  logic                take,
    input  logic [PIN_W-1:0]    take_pin,
    input  logic                eoi_valid,
    input  logic [PIN_W-1:0]    eoi_pin,
    output logic [NUM_PINS-1:0] req
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic act;
        logic prev_q;
        logic pend_q;
        logic busy_q;
        logic hit;
        logic eoi_hit;
        logic edge_set;

        assign act      = pin_in[p] ^ pol_v[p];
        assign hit      = take && (take_pin == PIN_W'(p));
        assign eoi_hit  = eoi_valid && (eoi_pin == PIN_W'(p));
        assign edge_set = !trig_v[p] && act && !prev_q && !mask_v[p];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                pend_q <= 1'b0;
                busy_q <= 1'b0;
            end else begin
                prev_q <= act;
                pend_q <= edge_set | (pend_q & !hit);
                busy_q <= (hit & trig_v[p]) | (busy_q & !eoi_hit);
            end
        end

        assign req[p] = !mask_v[p] && (trig_v[p] ? (act && !busy_q) : pend_q);

        // R6: a latched edge persists until its message is taken
        p_edge_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q && !hit) |=> pend_q);

        // R7: a serviced level pin stays blocked until its end-of-interrupt
        p_level_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_q && !eoi_hit) |=> busy_q);
    end

endmodule

// File: rtl/irq_route_sched.sv
`timescale 1ns/1ps
module irq_route_sched
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 16,
    localparam int PIN_W   = $clog2(NUM_PINS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_PINS-1:0]           req,
    input  logic [NUM_PINS-1:0]           mask_v,
    input  msg_pay_t [NUM_PINS-1:0]       pay,
    input  logic                          msg_ready,
    output logic                          msg_valid,
    output logic [PIN_W-1:0]              msg_pin,
    output msg_pay_t                      msg_pay,
    output logic                          take,
    output logic [PIN_W-1:0]              take_pin
);

    sched_st_e          state_q;
    sched_st_e          state_d;
    logic [PIN_W-1:0]   pick;
    logic               any_req;
    logic [PIN_W-1:0]   cur_pin_q;
    msg_pay_t           cur_pay_q;

    assign any_req = |req;

    always_comb begin
        pick = '0;
        for (int p = NUM_PINS - 1; p >= 0; p--) begin
            if (req[p])
                pick = PIN_W'(p);
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_SCAN;
        else
            state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        msg_valid = 1'b0;
        take      = 1'b0;
        unique case (state_q)
            ST_SCAN: begin
                if (any_req)
                    state_d = ST_HOLD;
            end
            ST_HOLD: begin
                msg_valid = 1'b1;
                if (msg_ready) begin
                    take    = 1'b1;
                    state_d = ST_SCAN;
                end
            end
            default: state_d = ST_SCAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_pin_q <= '0;
            cur_pay_q <= '0;
        end else if (state_q == ST_SCAN && any_req) begin
            cur_pin_q <= pick;
            cur_pay_q <= pay[pick];
        end
    end

    assign msg_pin  = cur_pin_q;
    assign msg_pay  = cur_pay_q;
    assign take_pin = cur_pin_q;

    // checker-side history of requests and masks
    logic [NUM_PINS-1:0] req_seen_q;
    logic [NUM_PINS-1:0] mask_seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_seen_q  <= '0;
            mask_seen_q <= '1;
        end else begin
            req_seen_q  <= req;
            mask_seen_q <= mask_v;
        end
    end

    // R9: an offered message holds until taken
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_pin) && $stable(msg_pay)));

    // R9: one message per acceptance
    p_one_per_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !msg_valid);

    // R8: no lower-numbered pin was requesting when this one was picked
    p_lowest_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> ((req_seen_q & ((NUM_PINS'(1) << msg_pin) - NUM_PINS'(1))) == '0));

    // R5: every offered message came from an unmasked, requesting pin
    p_from_request_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> (req_seen_q[msg_pin] && !mask_seen_q[msg_pin]));

endmodule

// File: rtl/irq_route_ctrl.sv
`timescale 1ns/1ps
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int IDX_W    = 8,
    parameter int BASE_IDX = 16,
    parameter int ID_RESET = 0,
    localparam int PIN_W   = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_we,
    input  logic [IDX_W-1:0]    sel_wdata,
    input  logic                win_we,
    input  logic [31:0]         win_wdata,
    output logic [31:0]         win_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                eoi_valid,
    input  logic [PIN_W-1:0]    eoi_pin,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [PIN_W-1:0]    msg_pin,
    output logic [7:0]          msg_vector,
    output logic [2:0]          msg_dlv,
    output logic                msg_dmode,
    output logic [3:0]          msg_dest
);

    rte_t [NUM_PINS-1:0]     tbl;
    msg_pay_t [NUM_PINS-1:0] pay;
    logic [NUM_PINS-1:0]     mask_v;
    logic [NUM_PINS-1:0]     trig_v;
    logic [NUM_PINS-1:0]     pol_v;
    logic [NUM_PINS-1:0]     req;
    logic                    take;
    logic [PIN_W-1:0]        take_pin;
    msg_pay_t                out_pay;

    irq_route_regs #(
        .NUM_PINS (NUM_PINS),
        .IDX_W    (IDX_W),
        .BASE_IDX (BASE_IDX),
        .ID_W     (DEST_W),
        .ID_RESET (ID_RESET)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_we    (sel_we),
        .sel_wdata (sel_wdata),
        .win_we    (win_we),
        .win_wdata (win_wdata),
        .win_rdata (win_rdata),
        .tbl       (tbl)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_split
        assign mask_v[p]    = tbl[p].mask;
        assign trig_v[p]    = tbl[p].trig;
        assign pol_v[p]     = tbl[p].pol;
        assign pay[p].vec   = tbl[p].vec;
        assign pay[p].dlv   = tbl[p].dlv;
        assign pay[p].dmode = tbl[p].dmode;
        assign pay[p].dest  = tbl[p].dest;
    end

    irq_route_capture #(
        .NUM_PINS (NUM_PINS)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .mask_v    (mask_v),
        .trig_v    (trig_v),
        .pol_v     (pol_v),
        .take      (take),
        .take_pin  (take_pin),
        .eoi_valid (eoi_valid),
        .eoi_pin   (eoi_pin),
        .req       (req)
    );

    irq_route_sched #(
        .NUM_PINS (NUM_PINS)
    ) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .mask_v    (mask_v),
        .pay       (pay),
        .msg_ready (msg_ready),
        .msg_valid (msg_valid),
        .msg_pin   (msg_pin),
        .msg_pay   (out_pay),
        .take      (take),
        .take_pin  (take_pin)
    );

    assign msg_vector = out_pay.vec;
    assign msg_dlv    = out_pay.dlv;
    assign msg_dmode  = out_pay.dmode;
    assign msg_dest   = out_pay.dest;

endmodule

// File: tb/irq_route_ctrl_test.sv
`timescale 1ns/1ps
module irq_route_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_we = 1'b0;
    logic [7:0]  sel_wdata = '0;
    logic        win_we = 1'b0;
    logic [31:0] win_wdata = '0;
    logic [31:0] win_rdata;
    logic [15:0] pin_in = '0;
    logic        eoi_valid = 1'b0;
    logic [3:0]  eoi_pin = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [3:0]  msg_pin;
    logic [7:0]  msg_vector;
    logic [2:0]  msg_dlv;
    logic        msg_dmode;
    logic [3:0]  msg_dest;

    always #4 clk = ~clk;

    irq_route_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
        .win_we(win_we), .win_wdata(win_wdata), .win_rdata(win_rdata),
        .pin_in(pin_in), .eoi_valid(eoi_valid), .eoi_pin(eoi_pin),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_pin(msg_pin),
        .msg_vector(msg_vector), .msg_dlv(msg_dlv), .msg_dmode(msg_dmode),
        .msg_dest(msg_dest)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit [7:0] m_sel;
    bit [3:0] m_id;
    bit [7:0] m_vec [16];
    bit [2:0] m_dlv [16];
    bit       m_dm [16];
    bit       m_pol [16];
    bit       m_trig [16];
    bit       m_mask [16];
    bit [3:0] m_dest [16];
    bit       m_prev [16];
    bit       m_pend [16];
    bit       m_svc [16];
    bit       m_busy;
    int       m_pin;
    bit [7:0] o_vec;
    bit [2:0] o_dlv;
    bit       o_dm;
    bit [3:0] o_dest;
    bit       t_act [16];
    bit       t_req [16];

    function automatic bit [31:0] m_read();
        int off;
        if (m_sel == 0) return {4'h0, m_id, 24'h0};
        if (m_sel >= 16 && m_sel <= 47) begin
            off = int'(m_sel) - 16;
            if (off % 2 == 1) return {4'h0, m_dest[off/2], 24'h0};
            return {15'h0, m_mask[off/2], m_trig[off/2], 1'b0, m_pol[off/2], 1'b0,
                    m_dm[off/2], m_dlv[off/2], m_vec[off/2]};
        end
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = 0; m_id = 0; m_busy = 0; m_pin = 0;
            o_vec = 0; o_dlv = 0; o_dm = 0; o_dest = 0;
            for (int p = 0; p < 16; p++) begin
                m_vec[p] = 0; m_dlv[p] = 0; m_dm[p] = 0; m_pol[p] = 0;
                m_trig[p] = 0; m_mask[p] = 1; m_dest[p] = 0;
                m_prev[p] = 0; m_pend[p] = 0; m_svc[p] = 0;
            end
        end else begin
            bit acc;
            int pick;
            acc = m_busy && msg_ready;
            for (int p = 0; p < 16; p++) begin
                t_act[p] = pin_in[p] ^ m_pol[p];
                t_req[p] = !m_mask[p] && (m_trig[p] ? (t_act[p] && !m_svc[p]) : m_pend[p]);
            end
            for (int p = 0; p < 16; p++) begin
                bit hit;
                hit = acc && (m_pin == p);
                if (!m_trig[p] && t_act[p] && !m_prev[p] && !m_mask[p]) m_pend[p] = 1;
                else if (hit) m_pend[p] = 0;
                if (hit && m_trig[p]) m_svc[p] = 1;
                else if (eoi_valid && eoi_pin == p) m_svc[p] = 0;
                m_prev[p] = t_act[p];
            end
            if (m_busy) begin
                if (msg_ready) m_busy = 0;
            end else begin
                pick = -1;
                for (int p = 15; p >= 0; p--) if (t_req[p]) pick = p;
                if (pick >= 0) begin
                    m_busy = 1; m_pin = pick;
                    o_vec = m_vec[pick]; o_dlv = m_dlv[pick];
                    o_dm = m_dm[pick]; o_dest = m_dest[pick];
                end
            end
            if (win_we) begin
                if (m_sel == 0) m_id = win_wdata[27:24];
                else if (m_sel >= 16 && m_sel <= 47) begin
                    int off;
                    off = int'(m_sel) - 16;
                    if (off % 2 == 1) m_dest[off/2] = win_wdata[27:24];
                    else begin
                        m_vec[off/2] = win_wdata[7:0]; m_dlv[off/2] = win_wdata[10:8];
                        m_dm[off/2] = win_wdata[11]; m_pol[off/2] = win_wdata[13];
                        m_trig[off/2] = win_wdata[15]; m_mask[off/2] = win_wdata[16];
                    end
                end
            end
            if (sel_we) m_sel = sel_wdata;
        end
    end

    // compare with the model every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(msg_valid == m_busy, "R9 valid vs model", 32'(msg_valid), 32'(m_busy));
            if (m_busy) begin
                chk(msg_pin == m_pin[3:0], "R8 pin vs model", 32'(msg_pin), 32'(m_pin));
                chk({msg_vector, msg_dlv, msg_dmode, msg_dest} == {o_vec, o_dlv, o_dm, o_dest},
                    "R3 payload vs model", 32'({msg_vector, msg_dlv, msg_dmode, msg_dest}),
                    32'({o_vec, o_dlv, o_dm, o_dest}));
            end
            chk(win_rdata == m_read(), "R1 window vs model", win_rdata, m_read());
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic set_sel(input bit [7:0] idx);
        @(negedge clk); sel_we = 1; sel_wdata = idx;
        @(negedge clk); sel_we = 0;
    endtask

    task automatic wr_reg(input bit [7:0] idx, input bit [31:0] d);
        set_sel(idx);
        win_we = 1; win_wdata = d;
        @(negedge clk); win_we = 0;
    endtask

    task automatic rd_chk(input bit [7:0] idx, input bit [31:0] exp, input string tag);
        set_sel(idx);
        chk(win_rdata == exp, tag, win_rdata, exp);
    endtask

    task automatic quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(!msg_valid, tag, 32'(msg_valid), 32'h0);
        end
    endtask

    task automatic take_msg(input int pin, input bit [7:0] vec, input string tag);
        int n = 0;
        while (!msg_valid && n < 30) begin @(negedge clk); n++; end
        chk(msg_valid, {tag, " message offered"}, 32'(msg_valid), 32'h1);
        chk(msg_pin == pin[3:0], {tag, " pin"}, 32'(msg_pin), 32'(pin));
        chk(msg_vector == vec, {tag, " vector"}, 32'(msg_vector), 32'(vec));
        msg_ready = 1;
        @(negedge clk); msg_ready = 0;
        chk(!msg_valid, "R9 drop after accept", 32'(msg_valid), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!msg_valid, "R4 no message after reset", 32'(msg_valid), 32'h0);
        rd_chk(8'h00, 32'h0, "R2 id reset");
        rd_chk(8'h16, 32'h0001_0000, "R4 pin3 low reset");
        rd_chk(8'h17, 32'h0, "R4 pin3 high reset");

        wr_reg(8'h00, 32'hFFFF_FFFF);
        rd_chk(8'h00, 32'h0F00_0000, "R2 id write");
        wr_reg(8'h05, 32'hFFFF_FFFF);
        rd_chk(8'h05, 32'h0, "R10 unmapped read");
        wr_reg(8'h30, 32'hFFFF_FFFF);
        rd_chk(8'h30, 32'h0, "R10 past-table read");
        rd_chk(8'h00, 32'h0F00_0000, "R10 id untouched");
        rd_chk(8'h2F, 32'h0, "R10 pin15 high untouched");

        // masked edge is lost (R5)
        pin_in[5] = 1;
        quiet(6, "R5 masked pin silent");
        wr_reg(8'h1A, 32'h0000_0055);
        quiet(6, "R5 masked edge discarded");
        pin_in[5] = 0;
        @(negedge clk);
        pin_in[5] = 1;
        take_msg(5, 8'h55, "R6 edge after unmask");

        // layout and hold (R3, R9)
        wr_reg(8'h15, 32'hFAFF_FFFF);
        rd_chk(8'h15, 32'h0A00_0000, "R3 high word");
        wr_reg(8'h14, 32'h0000_5942);
        rd_chk(8'h14, 32'h0000_0942, "R3 low word");
        pin_in[2] = 1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            chk(msg_valid && msg_vector == 8'h42, "R9 held without ready",
                32'(msg_vector), 32'h42);
            @(negedge clk);
        end
        chk({msg_dlv, msg_dmode, msg_dest} == {3'd1, 1'b1, 4'hA}, "R3 message fields",
            32'({msg_dlv, msg_dmode, msg_dest}), 32'({3'd1, 1'b1, 4'hA}));
        take_msg(2, 8'h42, "R6 edge pin2");
        quiet(6, "R6 steady high no repeat");

        // priority (R8)
        wr_reg(8'h1E, 32'h0000_0071);
        wr_reg(8'h18, 32'h0000_0044);
        pin_in[7] = 1; pin_in[4] = 1;
        take_msg(4, 8'h44, "R8 lowest first");
        take_msg(7, 8'h71, "R8 next pin");

        // active-low edge (R6)
        pin_in[6] = 1;
        wr_reg(8'h1C, 32'h0000_2066);
        quiet(4, "R6 no edge on polarity write");
        pin_in[6] = 0;
        take_msg(6, 8'h66, "R6 falling edge active low");

        // level with end-of-interrupt (R7)
        wr_reg(8'h22, 32'h0000_A061);
        take_msg(9, 8'h61, "R7 level first");
        quiet(8, "R7 wait for eoi");
        eoi_valid = 1; eoi_pin = 4'd9;
        @(negedge clk); eoi_valid = 0;
        take_msg(9, 8'h61, "R7 resend while active");
        pin_in[9] = 1;
        @(negedge clk);
        eoi_valid = 1;
        @(negedge clk); eoi_valid = 0;
        quiet(8, "R7 inactive after eoi");

        // masked level pin (R5)
        wr_reg(8'h22, 32'h0001_A061);
        pin_in[9] = 0;
        quiet(8, "R5 masked level pin");

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule